// File: doc/BRIEF.md
# Tree-Based Job Load Balancer

This block spreads queued work across a small group of processing nodes. Every node owns a private last-in, first-out job stack. Its processor pushes new jobs onto the stack and pops jobs off it to run them, and the current depth of the stack is always visible as a job count. Alongside those local ports, a binary tree of selectors compares all the counts at once. The tree names the node holding the most jobs (the source) and the node holding the fewest (the destination). A switch stage then moves the top job of the source onto the top of the destination at the next clock edge.

Selection and the move are resolved combinationally inside one cycle, so no handshake is needed. A node whose processor is marked faulty drops out of the comparison: the tree forwards only the results of the other nodes, and that node's stack is never used as a source or a destination. Balancing runs only while the global enable is high. A move is skipped in any cycle where the source or destination is also serving a local request, and the tree then works from the updated counts in the following cycle.

Top module: `jq_balancer`

## Requirements
- R1: After synchronous reset every job count reads 0 and `xfer_fire` is low.
- R2: Each node stack is LIFO, and its count always equals its occupancy. A push to a full stack is ignored. A pop of an empty stack is ignored. A push and a pop in the same cycle on a non-empty stack replace the top entry and leave the count unchanged. On an empty stack, that same pair acts as a plain push. `pop_job` shows the current top entry.
- R3: When at least one node is not faulty, `xfer_src` names the non-faulty node with the largest count. Among equal counts it names the lowest index.
- R4: When at least one node is not faulty, `xfer_dst` names the non-faulty node with the smallest count. Among equal counts it names the lowest index. When every node is faulty, both `xfer_src` and `xfer_dst` read 0.
- R5: `xfer_fire` is high only when `balance_en` is high and the source count exceeds the destination count by at least 2. When it fires, the source count drops by one and the destination count rises by one at that clock edge, and the job moved is the former top of the source.
- R6: A node whose `fault` bit is 1 is never a source or destination of a move. Its local push and pop ports keep working.
- R7: An asserted push or pop request at the selected source or destination suppresses the move in that cycle.
- R8: No count ever exceeds DEPTH. A cycle with no local requests leaves the total job count across nodes unchanged, whether or not a move fires.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| balance_en | input | 1 | Global enable for job moves |
| fault | input | NUM_NODES | Per-node faulty-processor flag (excludes the node from balancing) |
| push_valid | input | NUM_NODES | Per-node local push request |
| push_job | input | NUM_NODES x JOB_W | Per-node job pushed |
| pop_req | input | NUM_NODES | Per-node local pop request |
| pop_job | output | NUM_NODES x JOB_W | Per-node top-of-stack job |
| job_count | output | NUM_NODES x CNT_W | Per-node number of held jobs |
| xfer_fire | output | 1 | A job moves at the coming edge |
| xfer_src | output | IDX_W | Selected source (fullest) node |
| xfer_dst | output | IDX_W | Selected destination (emptiest) node |

## Verification
The colliding pair is a local push or pop and a balancing move that both target the same node in the same cycle. The bench provokes this collision on purpose: a directed case pushes to the emptiest node while a move is pending. A long pseudo-random phase also mixes local requests with enabled balancing, so such collisions happen often. A cycle-level model in the bench derives the selection and the move, applies the suppression rule, and then compares the moved job's contents and every count on the following cycle.

// File: rtl/jq_pkg.sv
package jq_pkg;

    localparam int CAND_CNT_W = 8;
    localparam int CAND_IDX_W = 8;

    typedef struct packed {
        logic                  valid;
        logic [CAND_CNT_W-1:0] cnt;
        logic [CAND_IDX_W-1:0] idx;
    } cand_t;

    // lo covers lower node indices than hi; ties keep lo
    function automatic cand_t pick_max(input cand_t lo, input cand_t hi);
        if (!hi.valid)            return lo;
        else if (!lo.valid)       return hi;
        else if (hi.cnt > lo.cnt) return hi;
        else                      return lo;
    endfunction

    function automatic cand_t pick_min(input cand_t lo, input cand_t hi);
        if (!hi.valid)            return lo;
        else if (!lo.valid)       return hi;
        else if (hi.cnt < lo.cnt) return hi;
        else                      return lo;
    endfunction

endpackage

// File: rtl/jq_stack.sv
module jq_stack #(
    parameter int DEPTH = 4,
    parameter int JW    = 8,
    parameter int CW    = 3
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          push,
    input  logic [JW-1:0] push_job,
    input  logic          pop,
    input  logic          give,
    input  logic          take,
    input  logic [JW-1:0] in_job,
    output logic [JW-1:0] top_job,
    output logic [CW-1:0] count
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [JW-1:0] mem [DEPTH];
    logic [CW-1:0] cnt;
    logic [AW-1:0] top_a;
    logic [AW-1:0] wr_a;
    logic          full;
    logic          empty;

    assign top_a   = AW'(cnt - 1'b1);
    assign wr_a    = AW'(cnt);
    assign full    = (cnt == CW'(DEPTH));
    assign empty   = (cnt == '0);
    assign top_job = empty ? '0 : mem[top_a];
    assign count   = cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (give) begin
            cnt <= cnt - 1'b1;
        end else if (take) begin
            cnt <= cnt + 1'b1;
        end else if (push && pop && !empty) begin
            cnt <= cnt;
        end else if (pop && !empty) begin
            cnt <= cnt - 1'b1;
        end else if (push && !full) begin
            cnt <= cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst) begin
            if (give) begin
                // source side only shrinks
            end else if (take) begin
                mem[wr_a] <= in_job;
            end else if (push && pop && !empty) begin
                mem[top_a] <= push_job;
            end else if (push && !pop && !full) begin
                mem[wr_a] <= push_job;
            end else if (push && pop && empty) begin
                mem[wr_a] <= push_job;
            end
        end
    end

endmodule

// File: rtl/jq_select_tree.sv
module jq_select_tree
    import jq_pkg::*;
#(
    parameter int N  = 4,
    parameter int CW = 3
) (
    input  logic [N-1:0][CW-1:0] cnt,
    input  logic [N-1:0]         excl,
    output cand_t                max_c,
    output cand_t                min_c
);
    // heap layout: root at 1, leaves at N..2N-1; N is a power of two
    cand_t tmax [2*N];
    cand_t tmin [2*N];

    assign tmax[0] = '0;
    assign tmin[0] = '0;

    for (genvar k = 0; k < N; k++) begin : g_leaf
        assign tmax[N+k] = '{valid: !excl[k], cnt: CAND_CNT_W'(cnt[k]), idx: CAND_IDX_W'(k)};
        assign tmin[N+k] = '{valid: !excl[k], cnt: CAND_CNT_W'(cnt[k]), idx: CAND_IDX_W'(k)};
    end

    for (genvar i = 1; i < N; i++) begin : g_node
        assign tmax[i] = pick_max(tmax[2*i], tmax[2*i+1]);
        assign tmin[i] = pick_min(tmin[2*i], tmin[2*i+1]);
    end

    assign max_c = tmax[1];
    assign min_c = tmin[1];

endmodule

// File: rtl/jq_switch.sv
module jq_switch #(
    parameter int N  = 4,
    parameter int JW = 8,
    parameter int IW = 2
) (
    input  logic                 fire,
    input  logic [IW-1:0]        src,
    input  logic [IW-1:0]        dst,
    input  logic [N-1:0][JW-1:0] tops,
    output logic [N-1:0]         give,
    output logic [N-1:0]         take,
    output logic [JW-1:0]        job
);
    for (genvar k = 0; k < N; k++) begin : g_port
        assign give[k] = fire && (src == IW'(k));
        assign take[k] = fire && (dst == IW'(k));
    end

    assign job = tops[src];

endmodule

// File: rtl/jq_balancer.sv
module jq_balancer
    import jq_pkg::*;
#(
    parameter int NUM_NODES = 4,
    parameter int DEPTH     = 4,
    parameter int JOB_W     = 8,
    parameter int CNT_W     = $clog2(DEPTH + 1),
    parameter int IDX_W     = $clog2(NUM_NODES)
) (
    input  logic                             clk,
    input  logic                             rst,
    input  logic                             balance_en,
    input  logic [NUM_NODES-1:0]             fault,
    input  logic [NUM_NODES-1:0]             push_valid,
    input  logic [NUM_NODES-1:0][JOB_W-1:0]  push_job,
    input  logic [NUM_NODES-1:0]             pop_req,
    output logic [NUM_NODES-1:0][JOB_W-1:0]  pop_job,
    output logic [NUM_NODES-1:0][CNT_W-1:0]  job_count,
    output logic                             xfer_fire,
    output logic [IDX_W-1:0]                 xfer_src,
    output logic [IDX_W-1:0]                 xfer_dst
);
    cand_t                           max_c;
    cand_t                           min_c;
    logic [IDX_W-1:0]                src;
    logic [IDX_W-1:0]                dst;
    logic                            spread_ok;
    logic                            ends_busy;
    logic                            fire;
    logic [NUM_NODES-1:0]            give;
    logic [NUM_NODES-1:0]            take;
    logic [JOB_W-1:0]                moved_job;
    logic [NUM_NODES-1:0][JOB_W-1:0] tops;
    logic [NUM_NODES-1:0][CNT_W-1:0] counts;
    logic                            sel_unused;

    assign sel_unused = ^{max_c, min_c};

    jq_select_tree #(.N(NUM_NODES), .CW(CNT_W)) u_tree (
        .cnt   (counts),
        .excl  (fault),
        .max_c (max_c),
        .min_c (min_c)
    );

    assign src       = max_c.valid ? IDX_W'(max_c.idx) : '0;
    assign dst       = min_c.valid ? IDX_W'(min_c.idx) : '0;
    assign spread_ok = ({1'b0, max_c.cnt} >= ({1'b0, min_c.cnt} + 9'd2));
    assign ends_busy = push_valid[src] | pop_req[src] | push_valid[dst] | pop_req[dst];
    assign fire      = balance_en && max_c.valid && spread_ok && !ends_busy
                       && (counts[src] != '0) && (counts[dst] != CNT_W'(DEPTH));

    jq_switch #(.N(NUM_NODES), .JW(JOB_W), .IW(IDX_W)) u_switch (
        .fire (fire),
        .src  (src),
        .dst  (dst),
        .tops (tops),
        .give (give),
        .take (take),
        .job  (moved_job)
    );

    for (genvar k = 0; k < NUM_NODES; k++) begin : g_node
        jq_stack #(.DEPTH(DEPTH), .JW(JOB_W), .CW(CNT_W)) u_stack (
            .clk      (clk),
            .rst      (rst),
            .push     (push_valid[k]),
            .push_job (push_job[k]),
            .pop      (pop_req[k]),
            .give     (give[k]),
            .take     (take[k]),
            .in_job   (moved_job),
            .top_job  (tops[k]),
            .count    (counts[k])
        );
    end

    assign pop_job   = tops;
    assign job_count = counts;
    assign xfer_fire = fire;
    assign xfer_src  = src;
    assign xfer_dst  = dst;

endmodule

// File: rtl/jq_balancer_checks.sv
module jq_balancer_checks #(
    parameter int NUM_NODES = 4,
    parameter int DEPTH     = 4,
    parameter int CNT_W     = 3,
    parameter int IDX_W     = 2
) (
    input logic                            clk,
    input logic                            rst,
    input logic                            balance_en,
    input logic [NUM_NODES-1:0]            fault,
    input logic [NUM_NODES-1:0]            push_valid,
    input logic [NUM_NODES-1:0]            pop_req,
    input logic [NUM_NODES-1:0][CNT_W-1:0] job_count,
    input logic                            xfer_fire,
    input logic [IDX_W-1:0]                xfer_src,
    input logic [IDX_W-1:0]                xfer_dst
);
    function automatic int total(input logic [NUM_NODES-1:0][CNT_W-1:0] c);
        int s = 0;
        for (int k = 0; k < NUM_NODES; k++) s += int'(c[k]);
        return s;
    endfunction

    a_r5_spread: assert property (@(posedge clk) disable iff (rst)
        xfer_fire |-> balance_en &&
            (int'(job_count[xfer_src]) >= int'(job_count[xfer_dst]) + 2));

    a_r5_move: assert property (@(posedge clk) disable iff (rst)
        xfer_fire |=>
            (int'(job_count[$past(xfer_src)]) == int'($past(job_count[xfer_src])) - 1) &&
            (int'(job_count[$past(xfer_dst)]) == int'($past(job_count[xfer_dst])) + 1));

    a_r6_no_faulty_end: assert property (@(posedge clk) disable iff (rst)
        xfer_fire |-> !fault[xfer_src] && !fault[xfer_dst]);

    a_r7_quiet_ends: assert property (@(posedge clk) disable iff (rst)
        xfer_fire |-> !(push_valid[xfer_src] || pop_req[xfer_src] ||
                        push_valid[xfer_dst] || pop_req[xfer_dst]));

    a_r8_conserve: assert property (@(posedge clk) disable iff (rst)
        (push_valid == '0 && pop_req == '0) |=> total(job_count) == $past(total(job_count)));

    for (genvar k = 0; k < NUM_NODES; k++) begin : g_bound
        a_r8_bound: assert property (@(posedge clk) disable iff (rst)
            int'(job_count[k]) <= DEPTH);
    end

endmodule

bind jq_balancer jq_balancer_checks #(
    .NUM_NODES (NUM_NODES),
    .DEPTH     (DEPTH),
    .CNT_W     (CNT_W),
    .IDX_W     (IDX_W)
) u_checks (
    .clk        (clk),
    .rst        (rst),
    .balance_en (balance_en),
    .fault      (fault),
    .push_valid (push_valid),
    .pop_req    (pop_req),
    .job_count  (job_count),
    .xfer_fire  (xfer_fire),
    .xfer_src   (xfer_src),
    .xfer_dst   (xfer_dst)
);

// File: tb/jq_balancer_bench.sv
`timescale 1ns/1ps
module jq_balancer_bench;
    localparam int N  = 4;
    localparam int D  = 4;
    localparam int JW = 8;
    localparam int CW = 3;
    localparam int IW = 2;

    logic                 clk = 1'b0;
    logic                 rst;
    logic                 balance_en;
    logic [N-1:0]         fault;
    logic [N-1:0]         push_valid;
    logic [N-1:0][JW-1:0] push_job;
    logic [N-1:0]         pop_req;
    logic [N-1:0][JW-1:0] pop_job;
    logic [N-1:0][CW-1:0] job_count;
    logic                 xfer_fire;
    logic [IW-1:0]        xfer_src;
    logic [IW-1:0]        xfer_dst;

    always #2 clk = ~clk;

    jq_balancer #(.NUM_NODES(N), .DEPTH(D), .JOB_W(JW)) u_jq_balancer (
        .clk(clk), .rst(rst), .balance_en(balance_en), .fault(fault),
        .push_valid(push_valid), .push_job(push_job), .pop_req(pop_req),
        .pop_job(pop_job), .job_count(job_count), .xfer_fire(xfer_fire),
        .xfer_src(xfer_src), .xfer_dst(xfer_dst)
    );

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    logic [JW-1:0] m_mem [N][D];
    int            m_cnt [N];

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1; balance_en = 1'b0; fault = '0;
        push_valid = '0; pop_req = '0; push_job = '0;
        @(posedge clk); @(posedge clk);
        for (int k = 0; k < N; k++) m_cnt[k] = 0;
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic run_cycle(input logic en, input logic [N-1:0] flt,
                             input logic [N-1:0] pu, input logic [N-1:0] po,
                             input logic [N-1:0][JW-1:0] pj, input string fire_tag);
        int bmax, bmin, s, d, tot;
        bit efire;
        logic [JW-1:0] mv;
        balance_en = en; fault = flt; push_valid = pu; pop_req = po; push_job = pj;
        #1;
        tot = 0;
        for (int k = 0; k < N; k++) begin
            chk("R2", $sformatf("count node %0d", k), int'(job_count[k]), m_cnt[k]);
            tot += int'(job_count[k]);
            if (m_cnt[k] > 0)
                chk("R2", $sformatf("top node %0d", k), int'(pop_job[k]), int'(m_mem[k][m_cnt[k]-1]));
        end
        chk("R8", "total jobs", tot, m_cnt[0] + m_cnt[1] + m_cnt[2] + m_cnt[3]);
        bmax = -1; bmin = -1;
        for (int k = 0; k < N; k++) begin
            if (!flt[k]) begin
                if (bmax < 0 || m_cnt[k] > m_cnt[bmax]) bmax = k;
                if (bmin < 0 || m_cnt[k] < m_cnt[bmin]) bmin = k;
            end
        end
        s = (bmax < 0) ? 0 : bmax;
        d = (bmin < 0) ? 0 : bmin;
        efire = en && (bmax >= 0) && (m_cnt[s] - m_cnt[d] >= 2) &&
                !(pu[s] || po[s] || pu[d] || po[d]);
        chk("R3", "source index", int'(xfer_src), s);
        chk("R4", "destination index", int'(xfer_dst), d);
        chk(fire_tag, "fire", int'(xfer_fire), int'(efire));
        @(posedge clk);
        if (efire) begin
            mv = m_mem[s][m_cnt[s]-1];
            m_cnt[s]--;
            m_mem[d][m_cnt[d]] = mv;
            m_cnt[d]++;
        end
        for (int k = 0; k < N; k++) begin
            if (pu[k] && po[k] && m_cnt[k] > 0) begin
                m_mem[k][m_cnt[k]-1] = pj[k];
            end else if (po[k] && m_cnt[k] > 0) begin
                m_cnt[k]--;
            end else if (pu[k] && m_cnt[k] < D) begin
                m_mem[k][m_cnt[k]] = pj[k];
                m_cnt[k]++;
            end
        end
        @(negedge clk);
    endtask

    initial begin
        repeat (195000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL R5 watchdog actual=%0d expected=%0d", 1, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [N-1:0][JW-1:0] pj;
        logic [31:0] lf;
        int c [N];
        @(negedge clk);
        do_reset();
        // R1: state right after reset
        #1;
        for (int k = 0; k < N; k++) chk("R1", "count after reset", int'(job_count[k]), 0);
        chk("R1", "fire after reset", int'(xfer_fire), 0);

        // sweep: every fault mask x every count vector (R3, R4, R5, R6)
        for (int f = 0; f < 16; f++) begin
            for (int v = 0; v < 625; v++) begin
                do_reset();
                for (int k = 0; k < N; k++) c[k] = (v / (5 ** k)) % 5;
                for (int st = 0; st < D; st++) begin
                    logic [N-1:0] pu;
                    for (int k = 0; k < N; k++) begin
                        pu[k] = (st < c[k]);
                        pj[k] = JW'(v * 7 + k * 3 + st);
                    end
                    run_cycle(1'b0, N'(f), pu, '0, pj, "R5");
                end
                run_cycle(1'b1, N'(f), '0, '0, pj, (f != 0) ? "R6" : "R5");
                run_cycle(1'b0, N'(f), '0, '0, pj, "R5");
            end
        end

        // R7: a push to the emptiest node blocks the pending move
        do_reset();
        for (int st = 0; st < D; st++) begin
            for (int k = 0; k < N; k++) pj[k] = JW'(8'h40 + st);
            run_cycle(1'b0, '0, 4'b0001, '0, pj, "R5");
        end
        run_cycle(1'b1, '0, 4'b0010, '0, pj, "R7");
        run_cycle(1'b1, '0, '0, '0, pj, "R7");
        run_cycle(1'b1, '0, '0, 4'b0001, pj, "R7");
        run_cycle(1'b0, '0, '0, '0, pj, "R5");

        // R2 / R7 / R8: pseudo-random mixed traffic
        do_reset();
        lf = 32'h1234_5678;
        for (int i = 0; i < 4000; i++) begin
            logic [N-1:0] flt;
            lf ^= lf << 13; lf ^= lf >> 17; lf ^= lf << 5;
            flt = (lf[7:4] == 4'h0) ? lf[11:8] : '0;
            for (int k = 0; k < N; k++) pj[k] = JW'(lf[31:24] + 8'(k));
            run_cycle(lf[0] | lf[1], flt, lf[15:12], lf[19:16] & lf[23:20], pj, "R7");
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule